// File: doc/BRIEF.md
# Sequential Integer Remainder Unit

This block computes the remainder of two 64-bit register operands for an integer pipeline, one bit per clock. A 10-bit operation code picks one of four flavours: unsigned or signed, on full 64-bit operands or on the low 32 bits only. Word flavours widen their low halves before the work starts. Zero-extension is used for unsigned and sign-extension for signed. The result always leaves as a full 64-bit value.

Requests enter on a valid/ready handshake. `in_ready` is high only while the unit is idle, so a request offered while the unit is busy is simply not taken. Results leave on a second valid/ready handshake. When `out_ready` is low, `out_valid` and `out_data` hold their values, and the unit accepts no new request until the result has been taken.

A zero divisor, a signed overflow (most negative value divided by -1) and an unrecognised code are caught in the setup cycle. Each of these returns zero at once, without running the iterations.

Top module: `rem_unit`

## Requirements
- R1: Code 265 gives the unsigned 64-bit remainder `a mod b`, which is always below `b`.
- R2: Code 267 zero-extends `a[31:0]` and `b[31:0]` to 64 bits and returns their unsigned remainder in all 64 bits; `a[63:32]` and `b[63:32]` have no effect.
- R3: Code 777 returns the signed 64-bit remainder with truncating semantics. The result takes the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R4: Code 779 sign-extends `a[31:0]` and `b[31:0]` to 64 bits and returns the signed remainder as a full 64-bit two's-complement value.
- R5: A divisor of zero, after any widening, gives a result of 0 for every code.
- R6: Code 777 with `a = 0x8000000000000000` and `b` all ones gives 0. Code 779 with `a[31:0] = 0x80000000` and `b[31:0] = 0xFFFFFFFF` also gives 0.
- R7: Any code other than 265, 267, 777 or 779 gives 0.
- R8: For an ordinary request, `out_valid` first rises XLEN+2 clock edges after the edge that accepts it (66 at the default width).
- R9: For a request covered by R5, R6 or R7, `out_valid` rises one clock edge after acceptance.
- R10: `in_ready` goes low on the edge that accepts a request and stays low until the result handshake. A request offered while `in_ready` is low is never executed.
- R11: While `out_valid` is high and `out_ready` is low, both `out_valid` and `out_data` hold on the next cycle.
- R12: During and right after reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle; the request is taken on this edge |
| in_opc | input | 10 | Operation code (265, 267, 777, 779) |
| in_a | input | XLEN | Dividend register operand |
| in_b | input | XLEN | Divisor register operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | XLEN | Remainder, full width |

## Verification
The hardest conditions to reach from the ports are the word-width corners. A divisor whose upper half is non-zero but whose low half is zero must take the short path under code 267. An upper half full of junk must leave word results untouched. Random stimulus almost never produces either, so directed requests put junk in the upper halves on purpose: `0x1_0000_0000` as a divisor, and the minimum 32-bit value against -1 with differing upper bits. The consumer side drops `out_ready` at random so that held results are common. Extra requests are also pushed while the unit is mid-computation to show they are dropped.

// File: rtl/rem_pkg.sv
package rem_pkg;
  localparam int OPC_W = 10;

  localparam logic [OPC_W-1:0] OPC_UDW = 10'd265;
  localparam logic [OPC_W-1:0] OPC_UWD = 10'd267;
  localparam logic [OPC_W-1:0] OPC_SDW = 10'd777;
  localparam logic [OPC_W-1:0] OPC_SWD = 10'd779;

  typedef enum logic [2:0] {
    K_UDW,
    K_UWD,
    K_SDW,
    K_SWD,
    K_BAD
  } rem_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ITER,
    ST_FIX,
    ST_DONE
  } rem_state_e;
endpackage

// File: rtl/rem_decode.sv
module rem_decode
  import rem_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic             neg_a,
  output logic             special,
  output logic [XLEN-1:0]  mag_a,
  output logic [XLEN-1:0]  mag_b
);
  localparam int PAD = XLEN - WLEN;

  rem_kind_e kind;
  logic is_word, is_signed;
  logic [XLEN-1:0] a_e, b_e, min_e;
  logic neg_b;

  always_comb begin
    case (opc)
      OPC_UDW: kind = K_UDW;
      OPC_UWD: kind = K_UWD;
      OPC_SDW: kind = K_SDW;
      OPC_SWD: kind = K_SWD;
      default: kind = K_BAD;
    endcase
  end

  assign is_word   = (kind == K_UWD) || (kind == K_SWD);
  assign is_signed = (kind == K_SDW) || (kind == K_SWD);

  always_comb begin
    if (is_word) begin
      a_e   = {{PAD{is_signed & a[WLEN-1]}}, a[WLEN-1:0]};
      b_e   = {{PAD{is_signed & b[WLEN-1]}}, b[WLEN-1:0]};
      min_e = {{(PAD+1){1'b1}}, {(WLEN-1){1'b0}}};
    end else begin
      a_e   = a;
      b_e   = b;
      min_e = {1'b1, {(XLEN-1){1'b0}}};
    end
  end

  assign neg_a = is_signed & a_e[XLEN-1];
  assign neg_b = is_signed & b_e[XLEN-1];
  assign mag_a = neg_a ? (~a_e + 1'b1) : a_e;
  assign mag_b = neg_b ? (~b_e + 1'b1) : b_e;

  assign special = (kind == K_BAD) || (b_e == '0) ||
                   (is_signed && (a_e == min_e) && (b_e == {XLEN{1'b1}}));
endmodule

// File: rtl/rem_core.sv
module rem_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [XLEN-1:0] mag_a,
  input  logic [XLEN-1:0] mag_b,
  output logic [XLEN-1:0] rem
);
  logic [XLEN-1:0] div_q, shf_q, acc_q;
  logic [XLEN:0]   trial;
  logic [XLEN+1:0] diff;
  logic            borrow;

  assign trial  = {acc_q, shf_q[XLEN-1]};
  assign diff   = {1'b0, trial} - {2'b00, div_q};
  assign borrow = diff[XLEN+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      shf_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      div_q <= mag_b;
      shf_q <= mag_a;
      acc_q <= '0;
    end else if (step) begin
      shf_q <= {shf_q[XLEN-2:0], 1'b0};
      acc_q <= borrow ? trial[XLEN-1:0] : diff[XLEN-1:0];
    end
  end

  assign rem = acc_q;

  // R1
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (acc_q < div_q));
endmodule

// File: rtl/rem_fix.sv
module rem_fix #(
  parameter int XLEN = 64
) (
  input  logic            neg,
  input  logic [XLEN-1:0] mag,
  output logic [XLEN-1:0] res
);
  assign res = neg ? (~mag + 1'b1) : mag;
endmodule

// File: rtl/rem_unit.sv
module rem_unit
  import rem_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPC_W-1:0] in_opc,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_data
);
  localparam int CNT_W = $clog2(XLEN + 1);
  localparam logic [CNT_W-1:0] ITERS = CNT_W'(XLEN);

  rem_state_e       state_q;
  logic [OPC_W-1:0] opc_q;
  logic [XLEN-1:0]  a_q, b_q, res_q;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q;

  logic            dec_neg, dec_special;
  logic [XLEN-1:0] dec_mag_a, dec_mag_b, core_rem, fix_res;
  logic            core_load, core_step;

  rem_decode #(.XLEN(XLEN), .WLEN(WLEN)) u_decode (
    .opc     (opc_q),
    .a       (a_q),
    .b       (b_q),
    .neg_a   (dec_neg),
    .special (dec_special),
    .mag_a   (dec_mag_a),
    .mag_b   (dec_mag_b)
  );

  assign core_load = (state_q == ST_SETUP);
  assign core_step = (state_q == ST_ITER);

  rem_core #(.XLEN(XLEN)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (core_load),
    .step  (core_step),
    .mag_a (dec_mag_a),
    .mag_b (dec_mag_b),
    .rem   (core_rem)
  );

  rem_fix #(.XLEN(XLEN)) u_fix (
    .neg (neg_q),
    .mag (core_rem),
    .res (fix_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      opc_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          opc_q   <= in_opc;
          a_q     <= in_a;
          b_q     <= in_b;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          neg_q <= dec_neg;
          if (dec_special) begin
            res_q   <= '0;
            state_q <= ST_DONE;
          end else begin
            cnt_q   <= ITERS;
            state_q <= ST_ITER;
          end
        end
        ST_ITER: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          res_q   <= fix_res;
          state_q <= ST_DONE;
        end
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign out_data  = res_q;

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R10
  busy_until_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !in_ready);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  short_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && dec_special) |=> (out_valid && out_data == '0));

  // R8
  iter_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ITER) |-> (cnt_q != '0 && cnt_q <= ITERS));
endmodule

// File: tb/rem_unit_bench.sv
module rem_unit_bench;
  localparam int XLEN = 64;
  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  typedef struct {
    logic [63:0] data;
    int          lat;
    string       tag_d;
    string       tag_l;
    int          acc_cyc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_opc = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  exp_t sb_q[$];

  rem_unit u_rem_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opc(in_opc), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  function automatic exp_t model(logic [9:0] opc, logic [63:0] a, logic [63:0] b);
    exp_t e;
    longint sa, sb;
    logic [63:0] ua, ub;
    e.lat = XLEN + 2; e.tag_l = "R8"; e.data = '0; e.acc_cyc = 0;
    case (opc)
      10'd265: begin ua = a; ub = b; e.tag_d = "R1";
        if (ub == 0) e.tag_d = "R5"; else e.data = ua % ub; end
      10'd267: begin ua = {32'h0, a[31:0]}; ub = {32'h0, b[31:0]}; e.tag_d = "R2";
        if (ub == 0) e.tag_d = "R5"; else e.data = ua % ub; end
      10'd777: begin sa = a; sb = b; e.tag_d = "R3";
        if (sb == 0) e.tag_d = "R5";
        else if (a == MIN64 && sb == -1) e.tag_d = "R6";
        else e.data = 64'(sa % sb); end
      10'd779: begin sa = {{32{a[31]}}, a[31:0]}; sb = {{32{b[31]}}, b[31:0]}; e.tag_d = "R4";
        if (sb == 0) e.tag_d = "R5";
        else if (a[31:0] == 32'h8000_0000 && sb == -1) e.tag_d = "R6";
        else e.data = 64'(sa % sb); end
      default: e.tag_d = "R7";
    endcase
    if (e.tag_d == "R5" || e.tag_d == "R6" || e.tag_d == "R7") begin
      e.lat = 1; e.tag_l = "R9";
    end
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [9:0] opc, logic [63:0] a, logic [63:0] b, bit poke);
    exp_t e;
    @(negedge clk);
    in_opc = opc; in_a = a; in_b = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e = model(opc, a, b);
    e.acc_cyc = cyc + 1;
    sb_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0; in_a = r64(); in_b = r64();
    if (poke) begin
      // R10: an offer while busy must be ignored
      in_valid = 1'b1; in_opc = 10'd265; in_a = 64'd99; in_b = 64'd7;
      check(in_ready == 1'b0, "R10", "in_ready while busy", 64'(in_ready), 64'd0);
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    bit prev_ov = 0, prev_or = 0;
    logic [63:0] prev_d = '0;
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (out_valid && !prev_ov && sb_q.size() > 0)
        check(cyc - sb_q[0].acc_cyc == sb_q[0].lat, sb_q[0].tag_l, "latency",
              64'(cyc - sb_q[0].acc_cyc), 64'(sb_q[0].lat));
      if (prev_ov && !prev_or)
        check(out_valid && out_data == prev_d, "R11", "hold under back-pressure",
              out_data, prev_d);
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10", "unexpected result", out_data, 64'd0);
        end else begin
          e = sb_q.pop_front();
          check(out_data == e.data, e.tag_d, "result", out_data, e.data);
        end
      end
      prev_ov = out_valid; prev_or = out_ready; prev_d = out_data;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", sb_q.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] ops [4];
    ops[0] = 10'd265; ops[1] = 10'd267; ops[2] = 10'd777; ops[3] = 10'd779;
    repeat (3) @(negedge clk);
    // R12
    check(in_ready == 1'b1 && out_valid == 1'b0, "R12", "reset state",
          {62'd0, in_ready, out_valid}, 64'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R12", "after reset",
          {62'd0, in_ready, out_valid}, 64'b10);

    // R1 directed
    send(10'd265, 64'd100, 64'd7, 1);
    send(10'd265, 64'd0, 64'd5, 0);
    send(10'd265, 64'd5, 64'd5, 0);
    send(10'd265, 64'd3, 64'd10, 1);
    send(10'd265, '1, '1 - 64'd1, 0);
    send(10'd265, MIN64, 64'd3, 0);
    // R5
    send(10'd265, 64'd42, 64'd0, 1);
    send(10'd777, 64'd42, 64'd0, 0);
    send(10'd779, 64'd42, 64'hFFFF_0000_0000_0000, 0);
    // R2: junk in upper halves, and divisor with zero low half
    send(10'd267, 64'hDEAD_BEEF_0000_0011, 64'h1234_5678_0000_0005, 0);
    send(10'd267, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000, 0);
    send(10'd267, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0010, 1);
    // R3
    send(10'd777, -64'sd7, 64'd2, 0);
    send(10'd777, 64'd7, -64'sd2, 0);
    send(10'd777, MIN64, 64'd3, 0);
    send(10'd777, '1, MIN64, 0);
    send(10'd777, MIN64, MIN64, 0);
    // R6
    send(10'd777, MIN64, '1, 1);
    send(10'd779, 64'h1111_1111_8000_0000, 64'h2222_2222_FFFF_FFFF, 0);
    // R4
    send(10'd779, 64'h0000_0000_FFFF_FFF9, 64'h7777_7777_0000_0002, 0);
    send(10'd779, 64'hFFFF_FFFF_8000_0000, 64'd3, 0);
    send(10'd779, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFE, 0);
    // R7
    send(10'd266, 64'd100, 64'd7, 1);
    send(10'd0, 64'd100, 64'd7, 0);

    for (int i = 0; i < 150; i++) begin
      logic [63:0] a, b;
      a = r64(); b = r64();
      case ($urandom % 4)
        0: b = 64'($urandom % 20);
        1: b = -64'($urandom % 20);
        default: ;
      endcase
      send(ops[$urandom % 4], a, b, ($urandom % 8) == 0);
    end

    while (sb_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule